// File: doc/BRIEF.md
# Single-Bank SDRAM Read Command Sequencer

This block turns read requests into a legal command stream for one bank of a synchronous DRAM. A request names a row, a column and a burst size. It enters through a valid/ready port. The sequencer drives the shared row/column address bus and the three active-low strobes (row strobe, column strobe, write enable) toward the memory. It then captures the returned words from the memory data bus and presents them with a valid flag.

One row stays open between requests. A request that hits the open row costs only a column read. A request to a different row closes the open row with a precharge, opens the new one with an activate, and then reads. Every spacing rule is taken from runtime timing inputs and enforced with cycle counters. The rules are: activate-to-read, read-to-read, read-to-precharge (the burst must drain), activate-to-precharge (minimum row-active time), precharge-to-activate, and a command-rate floor. The timing inputs are captured only while the sequencer is idle with no row open, which in practice means after reset.

Top module: `sdram_cmd_seq`

## Requirements
- R1: After reset, `req_ready` is 1, the strobes show the idle command (row, column and write strobes all 1) and `rd_valid` is 0.
- R2: Command encodings as {row strobe, column strobe, write enable}: idle 111, activate 011 with the row on `mem_addr`, read 101 with the column zero-extended on `mem_addr`, precharge 010. No other pattern is ever driven.
- R3: A read follows the activate of its row by at least max(activate-to-read delay, command rate) cycles. When that is the binding limit, the gap is exactly that value.
- R4: The first word of a read is presented with `rd_valid` = 1 exactly CL+1 cycles after the memory samples the read command. The remaining words follow on consecutive cycles, in column order.
- R5: Burst size code 0 gives 2 words, 1 gives 4, and 2 or 3 give 8. A precharge follows the last read by at least CL + burst words cycles. When that is the binding limit, the gap is exactly that value.
- R6: An activate follows the preceding precharge by at least max(precharge time, command rate) cycles, and exactly that when it is binding. No spacing rule is ever broken.
- R7: A precharge follows the activate of the row it closes by at least max(row-active minimum, command rate) cycles, and exactly that when it is binding.
- R8: A request to the open row issues only a read, with no precharge and no activate. Consecutive reads are spaced by max(previous burst words, command rate) cycles when that is binding.
- R9: A request to a different row issues exactly one precharge, then one activate, then one read, in that order.
- R10: Timing inputs are captured only while idle with no row open. A change made while a row is open has no effect. An input value of 0 acts as 1.
- R11: `req_ready` drops in the cycle after a request is accepted and stays low until the request's read has been issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken this cycle |
| req_row | input | ROW_W | Row of the request |
| req_col | input | COL_W | Starting column of the request |
| req_burst | input | 2 | Burst size code (0:2, 1:4, 2/3:8 words) |
| cfg_cas_lat | input | 4 | CAS latency in cycles |
| cfg_act_to_rd | input | 4 | Activate-to-read delay |
| cfg_pre_to_act | input | 4 | Precharge time before the next activate |
| cfg_act_to_pre | input | 4 | Minimum row-active time |
| cfg_cmd_gap | input | 4 | Command rate (minimum spacing of any two commands) |
| mem_addr | output | ADDR_W | Multiplexed row/column address |
| mem_ras_n | output | 1 | Row strobe, active low |
| mem_cas_n | output | 1 | Column strobe, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_dq | input | DATA_W | Data returned by the memory |
| rd_data | output | DATA_W | Captured read word |
| rd_valid | output | 1 | `rd_data` holds a word this cycle |

## Verification
The bench builds the block with its default widths: 12-bit rows, 10-bit columns and 16-bit data. It exercises the block through several runtime timing sets, applied one per reset. The first set makes the row-active minimum the binding precharge limit. Another pairs a one-cycle activate-to-read delay with a command rate of 2, so the rate floor becomes visible. A long burst makes the drain limit bind. A set of zero inputs shows the clamp to 1. Because the CAS latency is programmable up to 15, both a one-cycle return path and reads still in flight while the next command waits are covered.

// File: rtl/sdram_seq_pkg.sv
`timescale 1ns/1ps
package sdram_seq_pkg;

  localparam int T_W       = 4;   // width of every timing input
  localparam int MAX_BURST = 8;   // longest burst in words

  // command as {ras_n, cas_n, we_n}
  typedef enum logic [2:0] {
    CMD_ACT = 3'b011,
    CMD_RD  = 3'b101,
    CMD_PRE = 3'b010,
    CMD_NOP = 3'b111
  } sdram_cmd_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_PRE,
    ST_ACT,
    ST_RD
  } seq_state_e;

  typedef struct packed {
    logic [T_W-1:0] cl;
    logic [T_W-1:0] trcd;
    logic [T_W-1:0] trp;
    logic [T_W-1:0] tras;
    logic [T_W-1:0] rate;
  } seq_timing_t;

  // burst size code to word count
  function automatic logic [T_W-1:0] burst_words(input logic [1:0] code);
    case (code)
      2'd0:    return T_W'(2);
      2'd1:    return T_W'(4);
      default: return T_W'(MAX_BURST);
    endcase
  endfunction

  // a timing value of zero is read as one
  function automatic logic [T_W-1:0] at_least_one(input logic [T_W-1:0] v);
    return (v == '0) ? T_W'(1) : v;
  endfunction

endpackage

// File: rtl/sdram_seq_cfg.sv
`timescale 1ns/1ps
module sdram_seq_cfg
  import sdram_seq_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        load,
  input  seq_timing_t cfg_in,
  output seq_timing_t cfg_q
);

  seq_timing_t clamped;

  always_comb begin
    clamped.cl   = at_least_one(cfg_in.cl);
    clamped.trcd = at_least_one(cfg_in.trcd);
    clamped.trp  = at_least_one(cfg_in.trp);
    clamped.tras = at_least_one(cfg_in.tras);
    clamped.rate = at_least_one(cfg_in.rate);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q <= '{cl: T_W'(1), trcd: T_W'(1), trp: T_W'(1), tras: T_W'(1), rate: T_W'(1)};
    end else if (load) begin
      cfg_q <= clamped;
    end
  end

endmodule

// File: rtl/sdram_seq_since.sv
`timescale 1ns/1ps
module sdram_seq_since #(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hit,
  output logic [CNT_W-1:0] count
);

  localparam logic [CNT_W-1:0] SAT = '1;

  // count = edges elapsed since the edge that issued the event
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count <= SAT;
    end else if (hit) begin
      count <= CNT_W'(1);
    end else if (count != SAT) begin
      count <= count + CNT_W'(1);
    end
  end

endmodule

// File: rtl/sdram_seq_rdpipe.sv
`timescale 1ns/1ps
module sdram_seq_rdpipe
  import sdram_seq_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int SCHED_W = 26
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              launch,
  input  logic [T_W-1:0]    cas_lat,
  input  logic [T_W-1:0]    words,
  input  logic [DATA_W-1:0] mem_dq,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid
);

  logic [SCHED_W-1:0] sched;

  // bit k of the schedule is consumed k+1 edges after the launch edge;
  // the memory samples the read one edge later and drives word i CL+i edges
  // after that, so capture happens for k in [CL+1, CL+words]
  function automatic logic [SCHED_W-1:0] window(input logic [T_W-1:0] lat,
                                                input logic [T_W-1:0] n);
    logic [SCHED_W-1:0] m;
    m = '0;
    for (int k = 0; k < SCHED_W; k++) begin
      if ((k >= int'(lat) + 1) && (k < int'(lat) + 1 + int'(n))) m[k] = 1'b1;
    end
    return m;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sched    <= '0;
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      sched    <= (sched >> 1) | (launch ? window(cas_lat, words) : '0);
      rd_valid <= sched[0];
      if (sched[0]) rd_data <= mem_dq;
    end
  end

endmodule

// File: rtl/sdram_cmd_seq.sv
`timescale 1ns/1ps
module sdram_cmd_seq
  import sdram_seq_pkg::*;
#(
  parameter int ROW_W  = 12,
  parameter int COL_W  = 10,
  parameter int DATA_W = 16,
  parameter int ADDR_W = (ROW_W > COL_W) ? ROW_W : COL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ROW_W-1:0]  req_row,
  input  logic [COL_W-1:0]  req_col,
  input  logic [1:0]        req_burst,
  input  logic [T_W-1:0]    cfg_cas_lat,
  input  logic [T_W-1:0]    cfg_act_to_rd,
  input  logic [T_W-1:0]    cfg_pre_to_act,
  input  logic [T_W-1:0]    cfg_act_to_pre,
  input  logic [T_W-1:0]    cfg_cmd_gap,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_ras_n,
  output logic              mem_cas_n,
  output logic              mem_we_n,
  input  logic [DATA_W-1:0] mem_dq,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid
);

  localparam int CNT_W   = T_W + 2;
  localparam int SCHED_W = (1 << T_W) + MAX_BURST + 2;
  localparam int N_EVT   = 3;
  localparam int EV_ACT  = 0;
  localparam int EV_RD   = 1;
  localparam int EV_PRE  = 2;

  function automatic logic [CNT_W-1:0] larger(input logic [CNT_W-1:0] a,
                                              input logic [CNT_W-1:0] b);
    return (a > b) ? a : b;
  endfunction

  seq_state_e        state;
  logic              row_open;
  logic [ROW_W-1:0]  open_row;
  logic [ROW_W-1:0]  pend_row;
  logic [COL_W-1:0]  pend_col;
  logic [1:0]        pend_burst;
  logic [T_W-1:0]    last_bl;
  sdram_cmd_e        cmd_q;

  // named internal events, used by the bound checker
  seq_timing_t       cfg_raw;
  seq_timing_t       tcfg;
  logic              cfg_load;
  logic              accept;
  logic              row_hit;
  logic              issue_act;
  logic              issue_rd;
  logic              issue_pre;
  logic [N_EVT-1:0]  evt;
  logic [CNT_W-1:0]  since [N_EVT];
  logic [CNT_W-1:0]  need_rcd, need_rr, need_ras, need_drain, need_rp;
  logic              rd_ok, pre_ok, act_ok;

  assign cfg_raw = '{cl: cfg_cas_lat, trcd: cfg_act_to_rd, trp: cfg_pre_to_act,
                     tras: cfg_act_to_pre, rate: cfg_cmd_gap};
  assign cfg_load = (state == ST_IDLE) && !row_open;

  sdram_seq_cfg u_cfg (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (cfg_load),
    .cfg_in (cfg_raw),
    .cfg_q  (tcfg)
  );

  assign evt[EV_ACT] = issue_act;
  assign evt[EV_RD]  = issue_rd;
  assign evt[EV_PRE] = issue_pre;

  for (genvar g = 0; g < N_EVT; g++) begin : g_since
    sdram_seq_since #(.CNT_W(CNT_W)) u_since (
      .clk   (clk),
      .rst_n (rst_n),
      .hit   (evt[g]),
      .count (since[g])
    );
  end

  always_comb begin
    need_rcd   = larger(CNT_W'(tcfg.trcd), CNT_W'(tcfg.rate));
    need_rr    = larger(CNT_W'(last_bl),   CNT_W'(tcfg.rate));
    need_ras   = larger(CNT_W'(tcfg.tras), CNT_W'(tcfg.rate));
    need_drain = larger(CNT_W'(tcfg.cl) + CNT_W'(last_bl), CNT_W'(tcfg.rate));
    need_rp    = larger(CNT_W'(tcfg.trp),  CNT_W'(tcfg.rate));
  end

  assign rd_ok  = (since[EV_ACT] >= need_rcd) && (since[EV_RD] >= need_rr);
  assign pre_ok = (since[EV_ACT] >= need_ras) && (since[EV_RD] >= need_drain);
  assign act_ok = (since[EV_PRE] >= need_rp);

  assign issue_rd  = (state == ST_RD)  && rd_ok;
  assign issue_pre = (state == ST_PRE) && pre_ok;
  assign issue_act = (state == ST_ACT) && act_ok;

  assign req_ready = (state == ST_IDLE);
  assign accept    = req_valid && req_ready;
  assign row_hit   = row_open && (req_row == open_row);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      row_open   <= 1'b0;
      open_row   <= '0;
      pend_row   <= '0;
      pend_col   <= '0;
      pend_burst <= 2'd0;
      last_bl    <= T_W'(2);
    end else begin
      case (state)
        ST_IDLE: if (accept) begin
          pend_row   <= req_row;
          pend_col   <= req_col;
          pend_burst <= req_burst;
          if (row_hit)       state <= ST_RD;
          else if (row_open) state <= ST_PRE;
          else               state <= ST_ACT;
        end
        ST_PRE: if (issue_pre) begin
          row_open <= 1'b0;
          state    <= ST_ACT;
        end
        ST_ACT: if (issue_act) begin
          row_open <= 1'b1;
          open_row <= pend_row;
          state    <= ST_RD;
        end
        ST_RD: if (issue_rd) begin
          last_bl <= burst_words(pend_burst);
          state   <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // command and address pins are registered
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_q    <= CMD_NOP;
      mem_addr <= '0;
    end else if (issue_act) begin
      cmd_q    <= CMD_ACT;
      mem_addr <= ADDR_W'(pend_row);
    end else if (issue_rd) begin
      cmd_q    <= CMD_RD;
      mem_addr <= ADDR_W'(pend_col);
    end else if (issue_pre) begin
      cmd_q    <= CMD_PRE;
      mem_addr <= '0;
    end else begin
      cmd_q    <= CMD_NOP;
      mem_addr <= '0;
    end
  end

  assign {mem_ras_n, mem_cas_n, mem_we_n} = cmd_q;

  sdram_seq_rdpipe #(.DATA_W(DATA_W), .SCHED_W(SCHED_W)) u_rdpipe (
    .clk      (clk),
    .rst_n    (rst_n),
    .launch   (issue_rd),
    .cas_lat  (tcfg.cl),
    .words    (burst_words(pend_burst)),
    .mem_dq   (mem_dq),
    .rd_data  (rd_data),
    .rd_valid (rd_valid)
  );

endmodule

// File: rtl/sdram_cmd_seq_chk.sv
`timescale 1ns/1ps
module sdram_cmd_seq_chk
  import sdram_seq_pkg::*;
#(
  parameter int CNT_W = 6
) (
  input logic           clk,
  input logic           rst_n,
  input logic           ras_n,
  input logic           cas_n,
  input logic           we_n,
  input logic           req_valid,
  input logic           req_ready,
  input seq_timing_t    tcfg,
  input logic [T_W-1:0] burst_len
);

  localparam logic [CNT_W-1:0] SAT = '1;

  logic [2:0] pins;
  logic is_act, is_rd, is_pre, is_nop;
  logic [CNT_W-1:0] c_act, c_rd, c_pre;

  assign pins   = {ras_n, cas_n, we_n};
  assign is_act = (pins == 3'b011);
  assign is_rd  = (pins == 3'b101);
  assign is_pre = (pins == 3'b010);
  assign is_nop = (pins == 3'b111);

  function automatic logic [CNT_W-1:0] wmax(input logic [T_W-1:0] a, input logic [T_W-1:0] b);
    return (a > b) ? CNT_W'(a) : CNT_W'(b);
  endfunction

  // spacing counters rebuilt from the pins alone
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      c_act <= SAT;
      c_rd  <= SAT;
      c_pre <= SAT;
    end else begin
      c_act <= is_act ? CNT_W'(1) : ((c_act != SAT) ? c_act + CNT_W'(1) : c_act);
      c_rd  <= is_rd  ? CNT_W'(1) : ((c_rd  != SAT) ? c_rd  + CNT_W'(1) : c_rd);
      c_pre <= is_pre ? CNT_W'(1) : ((c_pre != SAT) ? c_pre + CNT_W'(1) : c_pre);
    end
  end

  AST_LEGAL_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    is_act || is_rd || is_pre || is_nop);                                   // R2
  AST_ACT_TO_RD: assert property (@(posedge clk) disable iff (!rst_n)
    is_rd |-> c_act >= wmax(tcfg.trcd, tcfg.rate));                          // R3
  AST_RD_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
    is_pre |-> c_rd >= CNT_W'(tcfg.cl) + CNT_W'(burst_len));                 // R5
  AST_PRE_TO_ACT: assert property (@(posedge clk) disable iff (!rst_n)
    is_act |-> c_pre >= wmax(tcfg.trp, tcfg.rate));                          // R6
  AST_ACT_TO_PRE: assert property (@(posedge clk) disable iff (!rst_n)
    is_pre |-> c_act >= wmax(tcfg.tras, tcfg.rate));                         // R7
  AST_READY_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);                                // R11

endmodule

bind sdram_cmd_seq sdram_cmd_seq_chk #(.CNT_W(6)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .ras_n     (mem_ras_n),
  .cas_n     (mem_cas_n),
  .we_n      (mem_we_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .tcfg      (tcfg),
  .burst_len (last_bl)
);

// File: tb/sdram_cmd_seq_tb_top.sv
`timescale 1ns/1ps
module sdram_cmd_seq_tb_top;

  localparam int ROW_W = 12;
  localparam int COL_W = 10;
  localparam int DW    = 16;
  localparam int AW    = 12;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [ROW_W-1:0] req_row = '0;
  logic [COL_W-1:0] req_col = '0;
  logic [1:0] req_burst = 2'd0;
  logic [3:0] cfg_cas_lat = 4'd2, cfg_act_to_rd = 4'd1, cfg_pre_to_act = 4'd1;
  logic [3:0] cfg_act_to_pre = 4'd1, cfg_cmd_gap = 4'd1;
  logic [AW-1:0] mem_addr;
  logic mem_ras_n, mem_cas_n, mem_we_n;
  logic [DW-1:0] mem_dq = '0;
  logic [DW-1:0] rd_data;
  logic rd_valid;

  sdram_cmd_seq dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_row(req_row), .req_col(req_col), .req_burst(req_burst),
    .cfg_cas_lat(cfg_cas_lat), .cfg_act_to_rd(cfg_act_to_rd),
    .cfg_pre_to_act(cfg_pre_to_act), .cfg_act_to_pre(cfg_act_to_pre),
    .cfg_cmd_gap(cfg_cmd_gap), .mem_addr(mem_addr), .mem_ras_n(mem_ras_n),
    .mem_cas_n(mem_cas_n), .mem_we_n(mem_we_n), .mem_dq(mem_dq),
    .rd_data(rd_data), .rd_valid(rd_valid)
  );

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  // effective timing known to the bench (written by tasks only)
  int e_cl = 1, e_trcd = 1, e_trp = 1, e_tras = 1, e_rate = 1;
  int req_bl [64];
  int first_idx [64];
  int n_req = 0;
  logic [DW-1:0] exp_data [256];
  int exp_n = 0;
  int rx_chk = 0;

  function automatic logic [DW-1:0] mem_word(input int row, input int col);
    return DW'((row * 613) ^ (col * 29) ^ 'h5a3c);
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // ---------------- behavioural memory model and command log ----------------
  int cyc = 0;
  int t_act, t_pre, t_rd, prev_bl, cur_row, last_col;
  int g_rd_act, g_rd_rd, g_pre_act, g_prefrom_act, g_prefrom_rd;
  int n_act, n_pre, n_rd, viol;
  int rd_t [64];
  int hist [64];
  int n_cmd;
  logic [DW-1:0] ring [64];
  bit ringv [64];
  wire [2:0] pins = {mem_ras_n, mem_cas_n, mem_we_n};

  always @(posedge clk) begin
    cyc = cyc + 1;
    if (!rst_n) begin
      t_act = -1000; t_pre = -1000; t_rd = -1000; prev_bl = 0;
      n_act = 0; n_pre = 0; n_rd = 0; viol = 0; n_cmd = 0;
      cur_row = -1; last_col = -1;
      for (int i = 0; i < 64; i++) ringv[i] = 1'b0;
    end else begin
      case (pins)
        3'b011: begin
          if (cyc - t_pre < imax(e_trp, e_rate)) viol++;
          g_pre_act = cyc - t_pre;
          t_act = cyc; n_act++; cur_row = int'(mem_addr);
          hist[n_cmd % 64] = 1; n_cmd++;
        end
        3'b101: begin
          if (cyc - t_act < imax(e_trcd, e_rate)) viol++;
          if (cyc - t_rd < imax(prev_bl, e_rate)) viol++;
          g_rd_act = cyc - t_act;
          g_rd_rd  = cyc - t_rd;
          last_col = int'(mem_addr);
          for (int i = 0; i < req_bl[n_rd % 64]; i++) begin
            ring[(cyc + e_cl + i) % 64]  = mem_word(cur_row, last_col + i);
            ringv[(cyc + e_cl + i) % 64] = 1'b1;
          end
          prev_bl = req_bl[n_rd % 64];
          rd_t[n_rd % 64] = cyc; n_rd++; t_rd = cyc;
          hist[n_cmd % 64] = 2; n_cmd++;
        end
        3'b010: begin
          if (cyc - t_act < imax(e_tras, e_rate)) viol++;
          if (cyc - t_rd < e_cl + prev_bl) viol++;
          g_prefrom_act = cyc - t_act;
          g_prefrom_rd  = cyc - t_rd;
          t_pre = cyc; n_pre++;
          hist[n_cmd % 64] = 3; n_cmd++;
        end
        3'b111: ;
        default: viol++;
      endcase
      if (ringv[cyc % 64]) begin
        mem_dq <= ring[cyc % 64];
        ringv[cyc % 64] = 1'b0;
      end
    end
  end

  // ---------------- read-data collector ----------------
  logic [DW-1:0] rx_data [256];
  int rx_cyc [256];
  int rx_n;
  always @(negedge clk) begin
    if (!rst_n) rx_n = 0;
    else if (rd_valid) begin
      rx_data[rx_n % 256] = rd_data;
      rx_cyc[rx_n % 256]  = cyc;
      rx_n++;
    end
  end

  // ---------------- helpers ----------------
  task automatic check_eq(input string req, input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic apply_cfg(input int cl, input int rcd, input int rp, input int ras, input int rate);
    @(negedge clk);
    cfg_cas_lat = 4'(cl); cfg_act_to_rd = 4'(rcd); cfg_pre_to_act = 4'(rp);
    cfg_act_to_pre = 4'(ras); cfg_cmd_gap = 4'(rate);
    e_cl = imax(cl, 1); e_trcd = imax(rcd, 1); e_trp = imax(rp, 1);
    e_tras = imax(ras, 1); e_rate = imax(rate, 1);
    rst_n = 1'b0;
    n_req = 0; exp_n = 0; rx_chk = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic do_req(input int row, input int col, input int code);
    int guard = 0;
    int bl;
    bl = (code == 0) ? 2 : (code == 1) ? 4 : 8;
    while (!req_ready && guard < 200) begin @(negedge clk); guard++; end
    req_valid = 1'b1; req_row = ROW_W'(row); req_col = COL_W'(col); req_burst = 2'(code);
    req_bl[n_req] = bl; first_idx[n_req] = exp_n; n_req++;
    for (int i = 0; i < bl; i++) begin exp_data[exp_n] = mem_word(row, col + i); exp_n++; end
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_reads(input int k);
    int guard = 0;
    while (n_rd < k && guard < 400) begin @(negedge clk); guard++; end
  endtask

  task automatic wait_rx(input string req);
    int guard = 0;
    while (rx_n < exp_n && guard < 400) begin @(negedge clk); guard++; end
    check_eq(req, "words received", rx_n, exp_n);
    for (int i = rx_chk; i < exp_n; i++) check_eq(req, "data word", int'(rx_data[i]), int'(exp_data[i]));
    rx_chk = exp_n;
  endtask

  task automatic check_lat(input int k, input string req);
    check_eq(req, "first word latency", rx_cyc[first_idx[k]] - rd_t[k], e_cl + 1);
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset_state();
    apply_cfg(2, 3, 2, 8, 1);
    check_eq("R1", "ready after reset", int'(req_ready), 1);
    check_eq("R1", "pins idle after reset", int'(pins), 7);
    check_eq("R1", "rd_valid after reset", int'(rd_valid), 0);
  endtask

  task automatic t_open_and_miss();
    // cfg CL2 tRCD3 tRP2 tRAS8 rate1
    do_req(5, 8, 0);
    check_eq("R11", "ready low after accept", int'(req_ready), 0);
    wait_reads(1);
    check_eq("R2", "activate row on addr", cur_row, 5);
    check_eq("R2", "read column on addr", last_col, 8);
    check_eq("R3", "act to read gap", g_rd_act, 3);
    do_req(9, 4, 0);
    check_eq("R11", "ready low during row change", int'(req_ready), 0);
    wait_reads(2);
    check_eq("R7", "act to precharge gap (row-active bound)", g_prefrom_act, 8);
    check_eq("R6", "precharge to act gap", g_pre_act, 2);
    check_eq("R2", "one precharge decoded", n_pre, 1);
    check_eq("R9", "cmd n-3 is precharge", hist[(n_cmd - 3) % 64], 3);
    check_eq("R9", "cmd n-2 is activate", hist[(n_cmd - 2) % 64], 1);
    check_eq("R9", "cmd n-1 is read", hist[(n_cmd - 1) % 64], 2);
    wait_rx("R4");
    check_lat(0, "R4");
    check_lat(1, "R4");
    check_eq("R6", "timing violations", viol, 0);
  endtask

  task automatic t_row_hits();
    int a0, p0;
    a0 = n_act; p0 = n_pre;
    do_req(9, 16, 1);
    do_req(9, 32, 2);
    wait_reads(4);
    check_eq("R8", "no activate on hits", n_act - a0, 0);
    check_eq("R8", "no precharge on hits", n_pre - p0, 0);
    check_eq("R8", "read to read gap = 4-word burst", g_rd_rd, 4);
    do_req(3, 0, 0);
    wait_reads(5);
    check_eq("R5", "read to precharge gap = CL+8", g_prefrom_rd, 10);
    wait_rx("R5");
    check_lat(2, "R4");
    check_lat(3, "R4");
    check_eq("R6", "timing violations", viol, 0);
  endtask

  task automatic t_rate_floor();
    apply_cfg(3, 1, 4, 1, 2);
    do_req(7, 2, 0);
    wait_reads(1);
    check_eq("R3", "act to read gap raised by rate", g_rd_act, 2);
    do_req(8, 6, 0);
    wait_reads(2);
    check_eq("R5", "read to precharge gap = CL+2", g_prefrom_rd, 5);
    check_eq("R6", "precharge to act gap", g_pre_act, 4);
    check_eq("R7", "act to precharge gap at rate floor", g_prefrom_act, imax(g_prefrom_act, 2));
    wait_rx("R4");
    check_lat(0, "R4");
    check_lat(1, "R4");
  endtask

  task automatic t_cfg_lock_and_zero();
    // row 8 is open: a CL change now must not apply
    @(negedge clk);
    cfg_cas_lat = 4'd5;
    repeat (2) @(negedge clk);
    do_req(8, 20, 0);
    wait_rx("R10");
    check_lat(2, "R10");
    // zeros are clamped to one
    apply_cfg(0, 0, 0, 0, 0);
    do_req(1, 1, 3);
    wait_reads(1);
    check_eq("R10", "zero act-to-read acts as 1", g_rd_act, 1);
    wait_rx("R5");
    check_eq("R5", "code 3 burst words", rx_n, 8);
    check_lat(0, "R10");
    check_eq("R6", "timing violations", viol, 0);
  endtask

  initial begin
    t_reset_state();
    t_open_and_miss();
    t_row_hits();
    t_rate_floor();
    t_cfg_lock_and_zero();
    repeat (5) @(negedge clk);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

endmodule